// File: doc/BRIEF.md
# On-Screen Display Icon Sequencer and Highlight Timer

This block is the control core of a small on-screen display. It holds the display control code, the bar length, the selected icon set, and the sequencing fields. Its only sense of time is a one-cycle pulse issued once per vertical field.

With the sequence override set to automatic, the screen index steps through 0, 1, 2 and back to 0. Each step takes a programmable number of eight-field units. An override value instead holds the index on one chosen screen.

A highlight control code lights one button for 32 fields. After that, the block rewrites the code to the normal-colours code, and the readback shows the new value. Pixel rendering, icon storage and line locking sit downstream and are not part of this block.

Top module: `osd_seq_top`

## Requirements
- R1: After reset the control readback is 0x00, the sequencing readback is 0x04 (automatic, period field 4), the icon set is 0, the screen index is 0, `osd_on` is 0 and `hl_sel` is 0.
- R2: Control code (`ctl_wdata[2:0]`) 000 gives `osd_on`=0. Codes 001, 101 and 110 give `osd_on`=1 with `hl_sel`=0, and these codes never change by themselves.
- R3: Control code 010 gives `hl_sel`=1 (up), 100 gives 2 (down), 011 gives 3 (plus) and 111 gives 4 (minus). Each of them also gives `osd_on`=1.
- R4: After a highlight code is written, the code stays unchanged through 31 field pulses. On the 32nd pulse it becomes 001, the bar field (`ctl_rdata[7:3]`) is kept, and `ctl_rdata` shows the new value.
- R5: Writing a highlight code while a highlight is running restarts the 32-field count.
- R6: With override `alt_wdata[5:4]`=00 and period field `alt_wdata[3:0]`=P>0, the screen index advances 0→1→2→0 on every 8·P-th field pulse. Any write to the sequencing register restarts that count.
- R7: With override 00 and P=0, field pulses leave the screen index unchanged.
- R8: Override 01, 10 and 11 pin the screen index to 0, 1 and 2 respectively, whatever field pulses arrive.
- R9: Returning the override to 00 resumes sequencing from the pinned screen, with a full 8·P-field wait before the next step.
- R10: The icon set (`icn_wdata[3:0]`) appears on `icon_set`, and the bar length written in `ctl_wdata[7:3]` appears on `bar_len` and in `ctl_rdata[7:3]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| field_pulse | input | 1 | One-cycle strobe per vertical field |
| ctl_we | input | 1 | Write strobe for the control word |
| ctl_wdata | input | 8 | Bar length [7:3] and control code [2:0] |
| icn_we | input | 1 | Write strobe for the icon set |
| icn_wdata | input | 4 | Icon set select |
| alt_we | input | 1 | Write strobe for the sequencing word |
| alt_wdata | input | 8 | Override [5:4] and period field [3:0] |
| ctl_rdata | output | 8 | Control word readback |
| alt_rdata | output | 8 | Sequencing word readback |
| screen_idx | output | 2 | Displayed screen within the set |
| osd_on | output | 1 | Display window enabled |
| hl_sel | output | 3 | Highlight: 0 none, 1 up, 2 down, 3 plus, 4 minus |
| icon_set | output | 4 | Selected icon set |
| bar_len | output | 5 | Bar length, 0 to 31 |

## Verification
The bench looks for off-by-one errors at the 31st and 32nd field of a highlight. A timer that ends one field early or late, or that clears the bar bits on reversion, shows up in the readback. It also checks the screen index after 7 and 8 pulses with a period of one unit, which catches a step size of other than eight fields.

A second highlight written mid-count must live a full 32 fields; a timer that is not restarted reverts early. The bench also tests the three cases where the screen index must stay put: the period-zero hold, pinning by override, and resuming from the pinned screen. A design that ignores any of these would step, jump to screen 0, or advance too soon.

// File: rtl/osd_seq_pkg.sv
package osd_seq_pkg;
  localparam int CODE_W = 3;
  localparam int BAR_W  = 5;
  localparam int ICON_W = 4;
  localparam int PER_W  = 4;
  localparam int OVR_W  = 2;

  typedef enum logic [2:0] {
    HL_NONE  = 3'd0,
    HL_UP    = 3'd1,
    HL_DOWN  = 3'd2,
    HL_PLUS  = 3'd3,
    HL_MINUS = 3'd4
  } hl_e;

  localparam logic [CODE_W-1:0] CODE_OFF    = 3'b000;
  localparam logic [CODE_W-1:0] CODE_NORMAL = 3'b001;

  function automatic hl_e decode_hl(input logic [CODE_W-1:0] code);
    case (code)
      3'b010:  decode_hl = HL_UP;
      3'b100:  decode_hl = HL_DOWN;
      3'b011:  decode_hl = HL_PLUS;
      3'b111:  decode_hl = HL_MINUS;
      default: decode_hl = HL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/osd_ctl_regs.sv
module osd_ctl_regs
  import osd_seq_pkg::*;
#(
  parameter logic [7:0] ALT_RESET = 8'h04
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [7:0]        ctl_wdata,
  input  logic              icn_we,
  input  logic [ICON_W-1:0] icn_wdata,
  input  logic              alt_we,
  input  logic [7:0]        alt_wdata,
  input  logic              expire,
  output logic [CODE_W-1:0] code,
  output logic [BAR_W-1:0]  bar,
  output logic [ICON_W-1:0] icon,
  output logic [OVR_W-1:0]  ovr,
  output logic [PER_W-1:0]  period
);
  logic [CODE_W-1:0] code_d;
  logic [BAR_W-1:0]  bar_d;
  logic [ICON_W-1:0] icon_d;
  logic [OVR_W-1:0]  ovr_d;
  logic [PER_W-1:0]  period_d;

  always_comb begin
    code_d   = code;
    bar_d    = bar;
    icon_d   = icon;
    ovr_d    = ovr;
    period_d = period;
    if (ctl_we) begin
      code_d = ctl_wdata[CODE_W-1:0];
      bar_d  = ctl_wdata[7:CODE_W];
    end else if (expire) begin
      code_d = CODE_NORMAL;
    end
    if (icn_we) icon_d = icn_wdata;
    if (alt_we) begin
      ovr_d    = alt_wdata[PER_W+OVR_W-1:PER_W];
      period_d = alt_wdata[PER_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code   <= CODE_OFF;
      bar    <= '0;
      icon   <= '0;
      ovr    <= ALT_RESET[PER_W+OVR_W-1:PER_W];
      period <= ALT_RESET[PER_W-1:0];
    end else begin
      code   <= code_d;
      bar    <= bar_d;
      icon   <= icon_d;
      ovr    <= ovr_d;
      period <= period_d;
    end
  end

  // R4: an expiry without a competing write lands on the normal code
  assert_revert_normal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !ctl_we) |=> (code == CODE_NORMAL));
  // R2: non-highlight codes are never changed except by a write
  assert_plain_code_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (decode_hl(code) == HL_NONE && !ctl_we) |=> $stable(code));
endmodule

// File: rtl/osd_hl_timer.sv
module osd_hl_timer
  import osd_seq_pkg::*;
#(
  parameter int HL_FIELDS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              field_pulse,
  input  logic [CODE_W-1:0] code,
  input  logic              restart,
  output logic              expire
);
  localparam int CW = $clog2(HL_FIELDS);
  localparam logic [CW-1:0] LAST = CW'(HL_FIELDS - 1);

  logic [CW-1:0] cnt, cnt_d;
  logic          active;

  assign active = (decode_hl(code) != HL_NONE);
  assign expire = active && field_pulse && (cnt == LAST) && !restart;

  always_comb begin
    cnt_d = cnt;
    if (restart || !active)  cnt_d = '0;
    else if (field_pulse)    cnt_d = (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

  // R4: reversion only ever comes from a highlight code
  assert_expire_from_hl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> (decode_hl(code) != HL_NONE));
  // R5: a restart leaves the count at zero
  assert_restart_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == '0));
endmodule

// File: rtl/osd_screen_seq.sv
module osd_screen_seq
  import osd_seq_pkg::*;
#(
  parameter int UNIT_LOG2 = 3,
  parameter int N_SCREENS = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             field_pulse,
  input  logic             alt_we,
  input  logic [PER_W-1:0] period,
  input  logic [OVR_W-1:0] ovr,
  output logic [1:0]       screen
);
  localparam int FW = PER_W + UNIT_LOG2;
  localparam logic [1:0] LAST_SCR = 2'(N_SCREENS - 1);

  logic [FW-1:0] fcnt, fcnt_d;
  logic [FW-1:0] limit;
  logic [1:0]    screen_d;

  assign limit = {period, {UNIT_LOG2{1'b0}}} - FW'(1);

  always_comb begin
    fcnt_d   = fcnt;
    screen_d = screen;
    if (ovr != '0) begin
      screen_d = ovr - 2'd1;
      fcnt_d   = '0;
    end else if (alt_we) begin
      fcnt_d = '0;
    end else if (field_pulse && period != '0) begin
      if (fcnt == limit) begin
        fcnt_d   = '0;
        screen_d = (screen == LAST_SCR) ? 2'd0 : screen + 2'd1;
      end else begin
        fcnt_d = fcnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcnt   <= '0;
      screen <= '0;
    end else begin
      fcnt   <= fcnt_d;
      screen <= screen_d;
    end
  end

  assert_screen_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    screen <= LAST_SCR);
  assert_auto_needs_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr == '0 && !field_pulse) |=> $stable(screen));
  assert_zero_period_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr == '0 && period == '0) |=> $stable(screen));
  assert_override_pin_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr != '0) |=> (screen == $past(ovr) - 2'd1));
endmodule

// File: rtl/osd_seq_top.sv
module osd_seq_top
  import osd_seq_pkg::*;
#(
  parameter int HL_FIELDS = 32,
  parameter int UNIT_LOG2 = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       field_pulse,
  input  logic       ctl_we,
  input  logic [7:0] ctl_wdata,
  input  logic       icn_we,
  input  logic [3:0] icn_wdata,
  input  logic       alt_we,
  input  logic [7:0] alt_wdata,
  output logic [7:0] ctl_rdata,
  output logic [7:0] alt_rdata,
  output logic [1:0] screen_idx,
  output logic       osd_on,
  output logic [2:0] hl_sel,
  output logic [3:0] icon_set,
  output logic [4:0] bar_len
);
  logic [CODE_W-1:0] code;
  logic [BAR_W-1:0]  bar;
  logic [OVR_W-1:0]  ovr;
  logic [PER_W-1:0]  period;
  logic              expire;
  logic              restart;

  assign restart = ctl_we && (decode_hl(ctl_wdata[CODE_W-1:0]) != HL_NONE);

  osd_ctl_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .icn_we(icn_we), .icn_wdata(icn_wdata),
    .alt_we(alt_we), .alt_wdata(alt_wdata),
    .expire(expire),
    .code(code), .bar(bar), .icon(icon_set), .ovr(ovr), .period(period)
  );

  osd_hl_timer #(.HL_FIELDS(HL_FIELDS)) u_timer (
    .clk(clk), .rst_n(rst_n), .field_pulse(field_pulse),
    .code(code), .restart(restart), .expire(expire)
  );

  osd_screen_seq #(.UNIT_LOG2(UNIT_LOG2)) u_seq (
    .clk(clk), .rst_n(rst_n), .field_pulse(field_pulse), .alt_we(alt_we),
    .period(period), .ovr(ovr), .screen(screen_idx)
  );

  assign ctl_rdata = {bar, code};
  assign alt_rdata = {2'b00, ovr, period};
  assign osd_on    = (code != CODE_OFF);
  assign hl_sel    = decode_hl(code);
  assign bar_len   = bar;

  // R3: a highlight always comes with the window enabled
  assert_hl_implies_on_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hl_sel != HL_NONE) |-> osd_on);
endmodule

// File: tb/osd_seq_top_bench.sv
module osd_seq_top_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       field_pulse, ctl_we, icn_we, alt_we;
  logic [7:0] ctl_wdata, alt_wdata;
  logic [3:0] icn_wdata;
  logic [7:0] ctl_rdata, alt_rdata;
  logic [1:0] screen_idx;
  logic       osd_on;
  logic [2:0] hl_sel;
  logic [3:0] icon_set;
  logic [4:0] bar_len;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  osd_seq_top u_osd_seq_top (
    .clk(clk), .rst_n(rst_n), .field_pulse(field_pulse),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .icn_we(icn_we), .icn_wdata(icn_wdata),
    .alt_we(alt_we), .alt_wdata(alt_wdata),
    .ctl_rdata(ctl_rdata), .alt_rdata(alt_rdata), .screen_idx(screen_idx),
    .osd_on(osd_on), .hl_sel(hl_sel), .icon_set(icon_set), .bar_len(bar_len)
  );

  task automatic check(input string req, input string what,
                       input int actual, input int expected);
    n_tests++;
    if (actual != expected) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, actual, expected);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; field_pulse = 0; ctl_we = 0; icn_we = 0; alt_we = 0;
    ctl_wdata = 0; alt_wdata = 0; icn_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr_ctl(input logic [7:0] v);
    @(negedge clk); ctl_we = 1; ctl_wdata = v;
    @(negedge clk); ctl_we = 0;
    @(negedge clk);
  endtask

  task automatic wr_alt(input logic [7:0] v);
    @(negedge clk); alt_we = 1; alt_wdata = v;
    @(negedge clk); alt_we = 0;
    @(negedge clk);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); field_pulse = 1;
      @(negedge clk); field_pulse = 0;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    do_reset();
    check("R1", "ctl_rdata", ctl_rdata, 8'h00);
    check("R1", "alt_rdata", alt_rdata, 8'h04);
    check("R1", "icon_set", icon_set, 0);
    check("R1", "screen_idx", screen_idx, 0);
    check("R1", "osd_on", osd_on, 0);
    check("R1", "hl_sel", hl_sel, 0);
  endtask

  task automatic t_plain_codes();
    do_reset();
    wr_ctl(8'h01);
    check("R2", "on 001", osd_on, 1);
    check("R2", "hl 001", hl_sel, 0);
    wr_ctl(8'h05);
    check("R2", "on 101", osd_on, 1);
    check("R2", "hl 101", hl_sel, 0);
    wr_ctl(8'h06);
    pulses(40);
    check("R2", "on 110", osd_on, 1);
    check("R2", "code 110 kept", ctl_rdata, 8'h06);
    wr_ctl(8'h00);
    check("R2", "off 000", osd_on, 0);
  endtask

  task automatic t_hl_decode();
    do_reset();
    wr_ctl(8'h02); check("R3", "up", hl_sel, 1);
    check("R3", "on with hl", osd_on, 1);
    wr_ctl(8'h04); check("R3", "down", hl_sel, 2);
    wr_ctl(8'h03); check("R3", "plus", hl_sel, 3);
    wr_ctl(8'h07); check("R3", "minus", hl_sel, 4);
  endtask

  task automatic t_hl_expire();
    do_reset();
    wr_ctl(8'hA2);
    pulses(31);
    check("R4", "hl after 31", hl_sel, 1);
    check("R4", "rdata after 31", ctl_rdata, 8'hA2);
    pulses(1);
    check("R4", "hl after 32", hl_sel, 0);
    check("R4", "rdata after 32", ctl_rdata, 8'hA1);
    check("R4", "on after 32", osd_on, 1);
  endtask

  task automatic t_hl_restart();
    do_reset();
    wr_ctl(8'h02);
    pulses(20);
    wr_ctl(8'h07);
    pulses(31);
    check("R5", "minus after 31", hl_sel, 4);
    pulses(1);
    check("R5", "revert after 32", ctl_rdata, 8'h01);
  endtask

  task automatic t_auto_seq();
    do_reset();
    wr_alt(8'h01);
    pulses(7);  check("R6", "idx after 7", screen_idx, 0);
    pulses(1);  check("R6", "idx after 8", screen_idx, 1);
    pulses(8);  check("R6", "idx after 16", screen_idx, 2);
    pulses(8);  check("R6", "idx wraps", screen_idx, 0);
    wr_alt(8'h02);
    pulses(15); check("R6", "P=2 after 15", screen_idx, 0);
    pulses(1);  check("R6", "P=2 after 16", screen_idx, 1);
  endtask

  task automatic t_zero_period();
    do_reset();
    wr_alt(8'h01);
    pulses(8);
    wr_alt(8'h00);
    pulses(40);
    check("R7", "hold P=0", screen_idx, 1);
  endtask

  task automatic t_override();
    do_reset();
    wr_alt(8'h21); check("R8", "pin 10", screen_idx, 1);
    pulses(20);    check("R8", "pin holds", screen_idx, 1);
    wr_alt(8'h31); check("R8", "pin 11", screen_idx, 2);
    wr_alt(8'h11); check("R8", "pin 01", screen_idx, 0);
    check("R8", "alt readback", alt_rdata, 8'h11);
  endtask

  task automatic t_resume();
    do_reset();
    wr_alt(8'h21);
    pulses(5);
    wr_alt(8'h01);
    pulses(7); check("R9", "still pinned screen", screen_idx, 1);
    pulses(1); check("R9", "resumed step", screen_idx, 2);
  endtask

  task automatic t_fields();
    do_reset();
    @(negedge clk); icn_we = 1; icn_wdata = 4'hB;
    @(negedge clk); icn_we = 0;
    @(negedge clk);
    check("R10", "icon_set", icon_set, 11);
    wr_ctl(8'hF9);
    check("R10", "bar_len", bar_len, 31);
    check("R10", "ctl_rdata", ctl_rdata, 8'hF9);
  endtask

  initial begin
    t_reset();
    t_plain_codes();
    t_hl_decode();
    t_hl_expire();
    t_hl_restart();
    t_auto_seq();
    t_zero_period();
    t_override();
    t_resume();
    t_fields();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule